// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer

This block sits between a processor memory bus and a bank of multiplexed-address DRAM. The bus presents a linear address that is already latched, plus a level-sensitive read or write command that stays asserted for the whole bus cycle. The block splits the address into a row half and a column half. It opens the row with an active-low row strobe, and it switches the shared DRAM address pins from the row half to the column half. It then fires the active-low column strobe. The processor sees an ordinary linearly addressed memory that always answers inside a full-speed bus cycle and never asks for wait-states.

The mux switch and the column strobe do not come from a state machine. They are taps on a clocked delay chain that starts running when the row strobe goes low, so the sequence behaves like a fixed delay line. Writes are early writes. The write enable falls on the same clock edge as the row strobe, well before the column strobe. The block captures the write data at that falling edge and holds it on the DRAM data pins. Changes on the bus data after that edge therefore have no effect. When the command ends, all strobes release together, and a minimum precharge time runs before the next row strobe.

Top module: `dram_strobe_seq`

## Requirements
- R1: While rst_n is low and after reset, dram_ras_n, dram_cas_n and dram_we_n are 1, dram_col_sel is 0 and bus_rvalid is 0.
- R2: When idle with bus_rd or bus_wr high, dram_ras_n goes low at the next clock edge. At that time dram_col_sel is 0 and dram_addr carries the row half, which is the upper ADDR_W/2 bits of bus_addr.
- R3: dram_col_sel rises RAS_TO_MUX clock edges after dram_ras_n falls (default 1). From then on, dram_addr carries the column half, which is the lower ADDR_W/2 bits of bus_addr.
- R4: dram_cas_n falls MUX_TO_CAS clock edges after dram_col_sel rises (default 1). It is never low unless dram_ras_n is low and dram_col_sel is 1.
- R5: At the first clock edge after the command drops, dram_ras_n, dram_cas_n and dram_we_n all return to 1, and dram_col_sel and bus_rvalid return to 0, all on that same edge.
- R6: After dram_ras_n rises, it stays high for at least PRECHARGE clocks (default 2). A command that is present during precharge is held off. It starts exactly PRECHARGE edges after dram_ras_n rose.
- R7: On a write (bus_wr high), dram_we_n falls on the same edge as dram_ras_n. dram_wdata takes the value of bus_wdata sampled at that edge and holds it while dram_we_n is low, even if bus_wdata changes afterwards.
- R8: On a read (bus_rd high), dram_we_n stays 1. bus_rvalid rises one clock after dram_cas_n falls. bus_rdata carries the value that dram_rdata showed during that clock, and it holds that value until the command ends.
- R9: Every access completes with fixed timing and no wait request. Data written through the block at any linear address is returned by a later read of the same address from the DRAM array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Latched linear address |
| bus_rd | input | 1 | Memory read command, held for the bus cycle |
| bus_wr | input | 1 | Memory write command, held for the bus cycle |
| bus_wdata | input | DATA_W | Write data from the bus |
| bus_rdata | output | DATA_W | Read data returned to the bus |
| bus_rvalid | output | 1 | bus_rdata is valid |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_col_sel | output | 1 | Address mux select: 0 = row half, 1 = column half |
| dram_addr | output | ADDR_W/2 | Multiplexed DRAM address |
| dram_wdata | output | DATA_W | Data driven to the DRAM |
| dram_rdata | input | DATA_W | Data returned by the DRAM |

## Verification
The bench starts new commands right after a release, so they land inside precharge. A design that ignores precharge would drop the row strobe one clock early, and a design that loses the pending command would never open the row at all. Mid-write, it overwrites the bus data after the write enable has fallen. A design that tracks the bus instead of holding the value captured at the enable edge would store the wrong byte, and the later read-back exposes it. It checks the row half and the column half on the address pins at each strobe edge. A swapped or late mux would show the wrong nibble on those pins. The bench also times read data against the column strobe and the release against the drop of the command, which catches any strobe that releases a cycle late.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_PRE  = 2'd2
    } phase_e;
endpackage

// File: rtl/rcs_tap_chain.sv
// Clocked delay line: each stage passes the previous one along while run is
// high; dropping run clears every stage on the same edge.
module rcs_tap_chain #(
    parameter int LEN = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           din,
    output logic [LEN-1:0] taps_q
);
    logic [LEN-1:0] taps_d;

    for (genvar i = 0; i < LEN; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign taps_d[i] = run & din;
        end else begin : g_body
            assign taps_d[i] = run & taps_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= taps_d;
    end
endmodule

// File: rtl/rcs_addr_split.sv
// Picks the row (upper) or column (lower) half of the linear address.
module rcs_addr_split #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sel_col,
    output logic [ADDR_W/2-1:0] half
);
    localparam int HALF = ADDR_W / 2;

    always_comb begin
        if (sel_col) half = addr[HALF-1:0];
        else         half = addr[ADDR_W-1:HALF];
    end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import rcs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int RAS_TO_MUX = 1,
    parameter int MUX_TO_CAS = 1,
    parameter int PRECHARGE  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_col_sel,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic [DATA_W-1:0]   dram_wdata,
    input  logic [DATA_W-1:0]   dram_rdata
);
    localparam int TAP_LEN = RAS_TO_MUX + MUX_TO_CAS;
    localparam int CNT_W   = $clog2(PRECHARGE + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              ras;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic [TAP_LEN-1:0] taps_q;
    logic cmd, col_on, cas_on;

    assign cmd    = bus_rd | bus_wr;
    assign col_on = taps_q[RAS_TO_MUX-1];
    assign cas_on = taps_q[TAP_LEN-1];

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (cmd) begin
                    nxt_d.phase = PH_OPEN;
                    nxt_d.ras   = 1'b1;
                    nxt_d.we    = bus_wr;
                    if (bus_wr) nxt_d.wdata = bus_wdata;
                end
            end
            PH_OPEN: begin
                if (!cmd) begin
                    nxt_d.phase  = PH_PRE;
                    nxt_d.cnt    = CNT_W'(PRECHARGE - 1);
                    nxt_d.ras    = 1'b0;
                    nxt_d.we     = 1'b0;
                    nxt_d.rvalid = 1'b0;
                end else if (cas_on && !cur_q.we && !cur_q.rvalid) begin
                    nxt_d.rvalid = 1'b1;
                    nxt_d.rdata  = dram_rdata;
                end
            end
            PH_PRE: begin
                if (cur_q.cnt != '0) begin
                    nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                end else if (cmd) begin
                    nxt_d.phase = PH_OPEN;
                    nxt_d.ras   = 1'b1;
                    nxt_d.we    = bus_wr;
                    if (bus_wr) nxt_d.wdata = bus_wdata;
                end else begin
                    nxt_d.phase = PH_IDLE;
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    rcs_tap_chain #(.LEN(TAP_LEN)) u_taps (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (nxt_d.ras),
        .din    (cur_q.ras),
        .taps_q (taps_q)
    );

    rcs_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr    (bus_addr),
        .sel_col (col_on),
        .half    (dram_addr)
    );

    assign dram_ras_n   = ~cur_q.ras;
    assign dram_cas_n   = ~cas_on;
    assign dram_we_n    = ~cur_q.we;
    assign dram_col_sel = col_on;
    assign dram_wdata   = cur_q.wdata;
    assign bus_rdata    = cur_q.rdata;
    assign bus_rvalid   = cur_q.rvalid;

    // R3: the mux moves to the column only after the row strobe has been low a cycle
    a_r3_mux_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_col_sel) |-> !dram_ras_n && $past(!dram_ras_n));

    // R4: column strobe only inside an open row with the column address out
    a_r4_cas_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n && dram_col_sel);

    // R5: everything lets go on the edge the row strobe rises
    a_r5_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> dram_cas_n && dram_we_n && !dram_col_sel && !bus_rvalid);

    // R6: row strobe stays high across the precharge window
    if (PRECHARGE >= 2) begin : g_pre_chk
        a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dram_ras_n) |=> dram_ras_n);
    end

    // R7: early write, enable falls with the row strobe
    a_r7_early_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_we_n) |-> $fell(dram_ras_n));

    // R7: captured data stays put while the enable is low
    a_r7_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_we_n && $past(!dram_we_n)) |-> $stable(dram_wdata));

    // R8: read data is only flagged on a read with the column strobe low
    a_r8_rvalid_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> dram_we_n && !dram_cas_n);
endmodule

// File: tb/sim_dram_strobe_seq.sv
`timescale 1ns/1ps
module sim_dram_strobe_seq;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int HW = AW / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_col_sel;
    logic [HW-1:0] dram_addr;
    logic [DW-1:0] dram_wdata;
    logic [DW-1:0] dram_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dram_strobe_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_col_sel(dram_col_sel), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    // Behavioural DRAM array: row latched at RAS fall, column at CAS fall
    logic [DW-1:0] dram [0:(1<<AW)-1];
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    logic [HW-1:0] row_l = '0;
    logic [HW-1:0] col_l = '0;

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            dram[i]    = DW'(i * 7 + 3);
            ref_mem[i] = DW'(i * 7 + 3);
        end
    end

    always @(negedge dram_ras_n) row_l = dram_addr;
    always @(negedge dram_cas_n) begin
        col_l = dram_addr;
        if (!dram_we_n) dram[{row_l, dram_addr}] = dram_wdata;
    end
    assign dram_rdata = (!dram_cas_n && dram_we_n) ? dram[{row_l, col_l}] : '0;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard queue of expected read data
    logic [DW-1:0] exp_q [$];
    logic          rv_prev = 1'b0;
    logic          cas_prev = 1'b1;
    logic [DW-1:0] held = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rvalid && !rv_prev) begin
                chk("R8", "cas low one clock before valid", int'(cas_prev), 0);
                if (exp_q.size() == 0) begin
                    chk("R8", "unexpected read data", 1, 0);
                end else begin
                    chk("R8", "read data", int'(bus_rdata), int'(exp_q.pop_front()));
                end
                held = bus_rdata;
            end else if (bus_rvalid) begin
                chk("R8", "read data held", int'(bus_rdata), int'(held));
            end
            rv_prev  = bus_rvalid;
            cas_prev = dram_cas_n;
        end
    end

    // Driver: called at a negedge, returns at the negedge after release
    task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d,
                          int hold, int pre_wait, bit scramble);
        bus_addr  = a;
        bus_rd    = !wr;
        bus_wr    = wr;
        bus_wdata = d;
        if (wr) ref_mem[a] = d;
        else    exp_q.push_back(ref_mem[a]);
        for (int i = 0; i < pre_wait; i++) begin
            @(negedge clk);
            chk("R6", "ras held during precharge", int'(dram_ras_n), 1);
        end
        @(negedge clk);
        chk("R2", "ras low", int'(dram_ras_n), 0);
        chk("R2", "mux on row", int'(dram_col_sel), 0);
        chk("R2", "row address", int'(dram_addr), int'(a[AW-1:HW]));
        chk(wr ? "R7" : "R8", "we_n level", int'(dram_we_n), wr ? 0 : 1);
        if (wr) chk("R7", "captured data", int'(dram_wdata), int'(d));
        if (scramble) bus_wdata = ~d;
        @(negedge clk);
        chk("R3", "mux on column", int'(dram_col_sel), 1);
        chk("R3", "column address", int'(dram_addr), int'(a[HW-1:0]));
        chk("R4", "cas still high", int'(dram_cas_n), 1);
        @(negedge clk);
        chk("R4", "cas low", int'(dram_cas_n), 0);
        chk("R8", "no valid yet", int'(bus_rvalid), 0);
        if (wr) chk("R7", "data held", int'(dram_wdata), int'(d));
        for (int i = 3; i < hold; i++) begin
            @(negedge clk);
            if (!wr && i == 3) chk("R8", "valid one clock after cas", int'(bus_rvalid), 1);
        end
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R5", "ras released", int'(dram_ras_n), 1);
        chk("R5", "cas released", int'(dram_cas_n), 1);
        chk("R5", "we released", int'(dram_we_n), 1);
        chk("R5", "mux back to row", int'(dram_col_sel), 0);
        chk("R5", "valid cleared", int'(bus_rvalid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ras_n in reset", int'(dram_ras_n), 1);
        chk("R1", "cas_n in reset", int'(dram_cas_n), 1);
        chk("R1", "we_n in reset", int'(dram_we_n), 1);
        chk("R1", "mux in reset", int'(dram_col_sel), 0);
        chk("R1", "valid in reset", int'(bus_rvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ras_n after reset", int'(dram_ras_n), 1);

        // R9: back-to-back writes at corner addresses, each inside precharge
        access(1'b1, 8'h00, 8'h11, 3, 0, 1'b0);
        access(1'b1, 8'hFF, 8'hEE, 3, 1, 1'b0);
        access(1'b1, 8'hA5, 8'h3C, 4, 1, 1'b0);
        access(1'b1, 8'h5A, 8'hC3, 3, 1, 1'b0);
        // R7: bus data changes after the enable fell
        access(1'b1, 8'h42, 8'h96, 5, 1, 1'b1);
        // reads back, mixed holds
        access(1'b0, 8'h00, 8'h00, 4, 1, 1'b0);
        access(1'b0, 8'hFF, 8'h00, 6, 1, 1'b0);
        access(1'b0, 8'hA5, 8'h00, 4, 1, 1'b0);
        access(1'b0, 8'h5A, 8'h00, 5, 1, 1'b0);
        access(1'b0, 8'h42, 8'h00, 4, 1, 1'b0);
        // untouched location keeps its initial pattern
        access(1'b0, 8'h13, 8'h00, 4, 1, 1'b0);
        // R6: command arriving on the last precharge cycle starts at once
        @(negedge clk);
        access(1'b0, 8'hA5, 8'h00, 4, 0, 1'b0);
        repeat (4) @(negedge clk);
        access(1'b1, 8'h81, 8'h7E, 3, 0, 1'b0);
        access(1'b0, 8'h81, 8'h00, 4, 1, 1'b0);
        // R9: sweep of linear addresses
        for (int i = 0; i < 16; i++) begin
            access(1'b1, AW'(i * 37 + 11), DW'(i * 29 + 5), 3, 1, 1'b0);
        end
        for (int i = 0; i < 16; i++) begin
            access(1'b0, AW'(i * 37 + 11), 8'h00, 4 + (i % 3), 1, 1'b0);
        end
        repeat (2) @(negedge clk);
        chk("R8", "all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule